// File: doc/BRIEF.md
# Serial Frame Boundary Aligner

This block sits behind a serial link receiver. It takes a recovered bit stream, one bit for each cycle in which the bit enable is high. The stream carries fixed-length frames of 25 bits. Each frame holds a zero start bit, 22 data bits and two trailing guard bits.

The block first searches for the frame boundary by testing a sliding window at every bit position. It trusts a position only after several frames in a row have passed the framing rule. After that it delivers each frame's data as a 22-bit word with a one-cycle valid strobe, and it keeps checking the framing of every frame.

A single bad frame while locked raises a sticky boundary error and stops the output. A reset or a power-down request clears the error. Acquisition then starts again from an empty window.

Top module: `fa_frame_aligner`

## Requirements
- R1: After reset, `word_out` is all zeros and `word_vld`, `locked` and `bnd_err` are low. Whenever `locked` is low, `word_out` is all zeros.
- R2: Within a frame, the bits arrive in this order: the start bit first, then data bit 0 up to data bit 21, then the two guard bits. Data bit i of a delivered frame appears on `word_out[i]`.
- R3: A frame passes the framing rule only when its start bit is 0 and both guard bits equal the inverse of data bit 21. If either guard bit differs, the frame fails.
- R4: During the search, every bit position is tested as a possible frame start. Alignment is found after a run of bits of any length that holds no passing window.
- R5: `locked` rises only when 4 frames in a row, spaced exactly 25 accepted bits apart, have passed. The 4th of these frames is delivered in the cycle after its last bit, with `word_vld` high. No word is delivered before that.
- R6: A failing frame before lock is reached ends the current trial. The search resumes, no word is delivered and `locked` stays low.
- R7: While locked, each passing frame gives exactly one `word_vld` pulse, in the cycle after its last guard bit. `word_out` holds that frame's data until the next delivery.
- R8: While locked, one failing frame raises `bnd_err` in the cycle after its last bit. In that same cycle `locked` drops, `word_out` is cleared and no `word_vld` pulse is given.
- R9: `bnd_err` stays high and later bits are ignored until a reset or power-down request. After the request clears it, a new acquisition can lock again.
- R10: While `pwr_dn` is high, all outputs are held low from the next cycle on, and incoming bits are discarded.
- R11: A cycle with `bit_en` low has no effect, whatever value `bit_in` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_dn | input | 1 | Power-down request: clears the error and restarts acquisition |
| bit_in | input | 1 | Serial data bit |
| bit_en | input | 1 | Marks `bit_in` as a valid bit in this cycle |
| word_out | output | 22 | Recovered parallel data word |
| word_vld | output | 1 | One-cycle strobe for a newly delivered word |
| locked | output | 1 | Frame alignment established |
| bnd_err | output | 1 | Sticky boundary error seen while locked |

## Verification
The assertions assume that the stream always contains the bit enables needed to finish a frame. They also assume that `pwr_dn` is a level held for at least one full cycle, so the error and lock flags can be related to the frame-end event that comes just before them.

The stimulus leaves random gaps with `bit_en` low and random data on `bit_in` between valid bits. Before each acquisition it sends a run of ones, so that the first window to pass the framing rule is the true frame start. This keeps the lock cycle predictable while still sweeping the start position across many offsets.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    FA_HUNT   = 2'd0,
    FA_VERIFY = 2'd1,
    FA_LOCK   = 2'd2,
    FA_ERR    = 2'd3
  } fa_state_e;
endpackage

// File: rtl/fa_shifter.sv
module fa_shifter #(
  parameter int FRAME_W = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               shift,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] win_nxt,
  output logic               full_nxt
);
  localparam int CW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr;
  logic [CW-1:0]      fill;

  // Oldest bit sits at the MSB, the newest at bit 0.
  assign win_nxt  = {sr[FRAME_W-2:0], bit_in};
  assign full_nxt = (fill >= CW'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sr   <= '0;
      fill <= '0;
    end else if (shift) begin
      sr <= win_nxt;
      if (fill != CW'(FRAME_W)) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/fa_tracker.sv
module fa_tracker
  import fa_pkg::*;
#(
  parameter int FRAME_W = 25,
  parameter int TAIL_W  = 2,
  parameter int LOCK_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic              bit_en,
  input  logic              full_nxt,
  input  logic              lead_bit,
  input  logic              last_bit,
  input  logic [TAIL_W-1:0] tail_bits,
  output fa_state_e         state,
  output logic              emit,
  output logic              fail_evt,
  output logic              frame_end,
  output logic              frame_pass
);
  localparam int BCW = $clog2(FRAME_W);
  localparam int GW  = $clog2(LOCK_N + 1);

  // Framing rule: zero start bit, every guard bit inverse of the last data bit.
  function automatic logic frame_ok(input logic lead, input logic last,
                                    input logic [TAIL_W-1:0] tail);
    logic ok;
    ok = (lead == 1'b0);
    for (int i = 0; i < TAIL_W; i++) begin
      if (tail[i] == last) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic lock_reached(input logic [GW-1:0] g);
    return (int'(g) + 1) >= LOCK_N;
  endfunction

  fa_state_e      st_n;
  logic [BCW-1:0] bcnt, bcnt_n;
  logic [GW-1:0]  good, good_n;
  logic           at_end;

  assign frame_pass = frame_ok(lead_bit, last_bit, tail_bits);
  assign at_end     = (bcnt == BCW'(FRAME_W - 1));
  assign frame_end  = bit_en && !pwr_dn &&
                      (((state == FA_HUNT) && full_nxt) ||
                       (((state == FA_VERIFY) || (state == FA_LOCK)) && at_end));

  always_comb begin
    st_n     = state;
    bcnt_n   = bcnt;
    good_n   = good;
    emit     = 1'b0;
    fail_evt = 1'b0;
    if (bit_en && !pwr_dn) begin
      case (state)
        FA_HUNT: begin
          if (full_nxt && frame_pass) begin
            bcnt_n = '0;
            if (LOCK_N <= 1) begin
              st_n = FA_LOCK;
              emit = 1'b1;
            end else begin
              st_n   = FA_VERIFY;
              good_n = GW'(1);
            end
          end
        end
        FA_VERIFY: begin
          if (at_end) begin
            bcnt_n = '0;
            if (frame_pass) begin
              if (lock_reached(good)) begin
                st_n   = FA_LOCK;
                emit   = 1'b1;
                good_n = '0;
              end else begin
                good_n = good + 1'b1;
              end
            end else begin
              st_n   = FA_HUNT;
              good_n = '0;
            end
          end else begin
            bcnt_n = bcnt + 1'b1;
          end
        end
        FA_LOCK: begin
          if (at_end) begin
            bcnt_n = '0;
            if (frame_pass) emit = 1'b1;
            else begin
              st_n     = FA_ERR;
              fail_evt = 1'b1;
            end
          end else begin
            bcnt_n = bcnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_dn) begin
      state <= FA_HUNT;
      bcnt  <= '0;
      good  <= '0;
    end else begin
      state <= st_n;
      bcnt  <= bcnt_n;
      good  <= good_n;
    end
  end
endmodule

// File: rtl/fa_outreg.sv
module fa_outreg #(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic              emit,
  input  logic              fail_evt,
  input  logic [DATA_W-1:0] data_sl,
  output logic [DATA_W-1:0] word_out,
  output logic              word_vld
);
  // data_sl holds data bit 0 at its MSB (it arrived first).
  function automatic logic [DATA_W-1:0] data_of(input logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] d;
    for (int i = 0; i < DATA_W; i++) d[i] = s[DATA_W-1-i];
    return d;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_dn || fail_evt) begin
      word_out <= '0;
      word_vld <= 1'b0;
    end else if (emit) begin
      word_out <= data_of(data_sl);
      word_vld <= 1'b1;
    end else begin
      word_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/fa_frame_aligner.sv
module fa_frame_aligner
  import fa_pkg::*;
#(
  parameter int DATA_W = 22,
  parameter int TAIL_W = 2,
  parameter int LOCK_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic              bit_in,
  input  logic              bit_en,
  output logic [DATA_W-1:0] word_out,
  output logic              word_vld,
  output logic              locked,
  output logic              bnd_err
);
  localparam int FRAME_W = DATA_W + TAIL_W + 1;

  logic [FRAME_W-1:0] win_nxt;
  logic               full_nxt;
  fa_state_e          state;
  logic               emit, fail_evt, frame_end, frame_pass;

  fa_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pwr_dn),
    .shift    (bit_en),
    .bit_in   (bit_in),
    .win_nxt  (win_nxt),
    .full_nxt (full_nxt)
  );

  fa_tracker #(.FRAME_W(FRAME_W), .TAIL_W(TAIL_W), .LOCK_N(LOCK_N)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_dn     (pwr_dn),
    .bit_en     (bit_en),
    .full_nxt   (full_nxt),
    .lead_bit   (win_nxt[FRAME_W-1]),
    .last_bit   (win_nxt[TAIL_W]),
    .tail_bits  (win_nxt[TAIL_W-1:0]),
    .state      (state),
    .emit       (emit),
    .fail_evt   (fail_evt),
    .frame_end  (frame_end),
    .frame_pass (frame_pass)
  );

  fa_outreg #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .emit     (emit),
    .fail_evt (fail_evt),
    .data_sl  (win_nxt[FRAME_W-2:TAIL_W]),
    .word_out (word_out),
    .word_vld (word_vld)
  );

  assign locked  = (state == FA_LOCK);
  assign bnd_err = (state == FA_ERR);
endmodule

// File: rtl/fa_frame_aligner_chk.sv
module fa_frame_aligner_chk #(
  parameter int DATA_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_dn,
  input logic              bit_en,
  input logic [DATA_W-1:0] word_out,
  input logic              word_vld,
  input logic              locked,
  input logic              bnd_err,
  input logic              frame_end,
  input logic              frame_pass
);
  assert_unlocked_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (word_out == '0));

  assert_lock_delivers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> word_vld);

  assert_vld_when_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> locked);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bnd_err) |-> $past(frame_end && !frame_pass));

  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && bnd_err));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_err && !pwr_dn) |=> bnd_err);

  assert_pd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!word_vld && !locked && !bnd_err && word_out == '0));

  assert_vld_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_vld) |-> $past(bit_en));
endmodule

bind fa_frame_aligner fa_frame_aligner_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_dn     (pwr_dn),
  .bit_en     (bit_en),
  .word_out   (word_out),
  .word_vld   (word_vld),
  .locked     (locked),
  .bnd_err    (bnd_err),
  .frame_end  (frame_end),
  .frame_pass (frame_pass)
);

// File: tb/fa_frame_aligner_bench.sv
module fa_frame_aligner_bench;
  localparam int DW = 22;
  localparam int FW = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_dn = 1'b0;
  logic          bit_in = 1'b0;
  logic          bit_en = 1'b0;
  logic [DW-1:0] word_out;
  logic          word_vld, locked, bnd_err;

  int checks = 0;
  int fails = 0;
  int vld_cnt = 0;
  int exp_pulses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fa_frame_aligner u_fa_frame_aligner (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .bit_in(bit_in), .bit_en(bit_en),
    .word_out(word_out), .word_vld(word_vld), .locked(locked), .bnd_err(bnd_err)
  );

  always @(posedge clk) if (rst_n && word_vld) vld_cnt <= vld_cnt + 1;

  // Bit k of the result is the k-th bit sent. kind: 0 good, 1 bad start, 2 bad first guard, 3 bad second guard.
  function automatic logic [FW-1:0] mk_frame(input logic [DW-1:0] d, input int kind);
    logic [FW-1:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < DW; i++) f[1+i] = d[i];
    f[FW-2] = ~d[DW-1];
    f[FW-1] = ~d[DW-1];
    if (kind == 1) f[0] = 1'b1;
    if (kind == 2) f[FW-2] = ~f[FW-2];
    if (kind == 3) f[FW-1] = ~f[FW-1];
    return f;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    int idle;
    idle = $urandom_range(0, 2);
    repeat (idle) begin
      bit_en = 1'b0;
      bit_in = 1'($urandom);
      @(negedge clk);
    end
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    bit_in = 1'($urandom);
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input int kind);
    logic [FW-1:0] f;
    f = mk_frame(d, kind);
    for (int i = 0; i < FW; i++) send_bit(f[i]);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic acquire(input int pre);
    logic [DW-1:0] d;
    send_ones(pre);
    for (int k = 0; k < 3; k++) begin
      send_frame(DW'($urandom), 0);
      chk("R5 no lock before 4th frame", 32'(locked), 32'd0);
      chk("R5 no word before lock", 32'(vld_cnt), 32'(exp_pulses));
    end
    d = DW'($urandom);
    send_frame(d, 0);
    chk("R5 locked after 4th frame", 32'(locked), 32'd1);
    chk("R5 vld with 4th frame", 32'(word_vld), 32'd1);
    chk("R2 R4 data of 4th frame", 32'(word_out), 32'(d));
    exp_pulses++;
  endtask

  task automatic power_down();
    pwr_dn = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) send_bit(1'($urandom));
    chk("R10 word_out low", 32'(word_out), 32'd0);
    chk("R10 flags low", 32'({word_vld, locked, bnd_err}), 32'd0);
    pwr_dn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word_out", 32'(word_out), 32'd0);
    chk("R1 reset flags", 32'({word_vld, locked, bnd_err}), 32'd0);

    // first acquisition with no leading filler
    acquire(0);

    // random locked traffic, mixed with the two extreme data patterns
    for (int n = 0; n < 30; n++) begin
      if (n == 3) d = '0;
      else if (n == 4) d = '1;
      else d = DW'($urandom);
      send_frame(d, 0);
      chk("R7 vld after last guard bit", 32'(word_vld), 32'd1);
      chk("R2 R7 word data", 32'(word_out), 32'(d));
      chk("R7 one pulse per frame", 32'(vld_cnt), 32'(exp_pulses));
      exp_pulses++;
      @(negedge clk);
      chk("R7 word held after pulse", 32'(word_out), 32'(d));
    end

    // bad start bit while locked
    send_frame(DW'($urandom), 1);
    chk("R8 error raised", 32'(bnd_err), 32'd1);
    chk("R8 lock dropped", 32'(locked), 32'd0);
    chk("R8 word cleared", 32'(word_out), 32'd0);
    chk("R8 no vld on bad frame", 32'(word_vld), 32'd0);
    send_frame(DW'($urandom), 0);
    send_frame(DW'($urandom), 0);
    @(negedge clk);
    chk("R9 error sticky", 32'(bnd_err), 32'd1);
    chk("R9 no words while in error", 32'(vld_cnt), 32'(exp_pulses));

    power_down();
    chk("R9 error cleared by power-down", 32'(bnd_err), 32'd0);
    acquire(int'($urandom_range(3, 40)));

    // only the second guard bit wrong while locked
    send_frame(DW'($urandom), 3);
    chk("R3 second guard checked", 32'(bnd_err), 32'd1);
    power_down();

    // only the first guard bit wrong during verification
    send_ones(int'($urandom_range(1, 30)));
    send_frame(DW'($urandom), 0);
    send_frame(DW'($urandom), 0);
    send_frame(DW'($urandom), 2);
    chk("R6 R3 fail during verify, no lock", 32'(locked), 32'd0);
    chk("R6 fail during verify, no error", 32'(bnd_err), 32'd0);
    send_frame(DW'($urandom), 0);
    send_frame(DW'($urandom), 0);
    @(negedge clk);
    chk("R6 still hunting", 32'(locked), 32'd0);
    chk("R6 no word delivered", 32'(vld_cnt), 32'(exp_pulses));

    // reset also clears and restarts
    power_down();
    for (int r = 0; r < 6; r++) begin
      acquire(int'($urandom_range(0, 60)));
      chk("R11 R4 relock at random offset", 32'(locked), 32'd1);
      send_frame(DW'($urandom), 1 + (r % 3));
      chk("R8 failing frame flagged", 32'(bnd_err), 32'd1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 R9 reset clears error", 32'({word_vld, locked, bnd_err}), 32'd0);
      vld_cnt = 0;
      exp_pulses = 0;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule